// File: doc/BRIEF.md
# Delta-Stride Loop Address Generator

This block walks a nested loop of up to six levels and presents one memory address per iteration. Software-side tooling programs a starting address, the number of active levels, and one extent and one stride value for each level. A unified-buffer read or write port then raises `step_i` once per access, and `addr_o` moves to the next address in the pattern.

The stored values are pre-encoded so that the datapath stays small. Each extent is stored as the true trip count less two. Each stride is stored as the change in address to apply when that level is the outermost one to advance. That value is the absolute stride less whatever the inner levels added during their completed sweep. As a result, every step costs one comparison per level and one add. No multiplier is needed.

When the whole nest completes, the block pulses `done_o`, returns to the starting address and goes idle. While idle it follows the configuration inputs directly. Once a pass has begun, it works from a private copy of that configuration.

Top module: `loopaddr_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is idle, `done_o` is 0 and `addr_o` equals `cfg_start_i` zero-extended to 16 bits.
- R2: While idle, `addr_o` follows `cfg_start_i` (zero-extended) combinationally.
- R3: With `step_i` and `restart_i` both low, `addr_o` and all loop counters hold their values across the clock edge.
- R4: On a step, level 0 increments. A level sitting at its wrap value returns to 0 and passes a carry to the next level. Exactly one level takes the carry without wrapping, and `addr_o` grows by that level's delta at the same edge.
- R5: Extent field d (8 bits, at bits 8*d+7:8*d of `cfg_extent_i`) holds the trip count minus 2. Level d wraps when its counter equals the field plus 1.
- R6: Delta field d (16 bits, at bits 16*d+15:16*d of `cfg_delta_i`) equals the absolute stride of level d minus the sum, over every inner level i, of stride(i)·(trip(i)−1). The address sequence is therefore start + Σ count(d)·stride(d).
- R7: Only levels 0 to `cfg_dims_i`−1 are active. A value above 6 is treated as 6. The extent and delta fields of inactive levels have no effect on `addr_o` or `done_o`.
- R8: A step on which every active level wraps raises `done_o` for one cycle after the edge. At the same edge `addr_o` returns to the starting address, the counters clear and the block goes idle.
- R9: `restart_i` is synchronous and overrides `step_i`. It clears the counters, returns the block to idle (`addr_o` = start) and keeps `done_o` low.
- R10: The configuration is taken at the step that leaves idle. Later changes to the configuration inputs have no effect until the block is idle again.
- R11: The address adds are modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| restart_i | input | 1 | Synchronous return to idle at the start address |
| step_i | input | 1 | Advance the loop nest by one iteration |
| cfg_start_i | input | 3 | Starting address |
| cfg_dims_i | input | 3 | Number of active loop levels |
| cfg_extent_i | input | 48 | Per-level extent fields, trip count minus 2 |
| cfg_delta_i | input | 96 | Per-level relative address deltas |
| addr_o | output | 16 | Current address |
| done_o | output | 1 | One-cycle pulse when the nest completes |

## Verification
Some properties are checked on every cycle:
- At most one level takes the carry on a step.
- The address holds when there is no step or restart.
- While idle, including the cycle of a done pulse, the address equals the start input.
- A done pulse only ever follows a step with no restart.
- A restart always leaves the block idle with `done_o` low.

The bench's reference model is built only from absolute strides and true trip counts, so only its scenarios show three things: that the delta encoding reproduces the multiply-based address sequence, that wrap points and done timing match the extents, and that inactive levels and mid-pass configuration changes stay without effect.

// File: rtl/lag_pkg.sv
package lag_pkg;

  typedef enum logic [1:0] {
    ACT_HOLD    = 2'd0,
    ACT_ADVANCE = 2'd1,
    ACT_FINISH  = 2'd2,
    ACT_CLEAR   = 2'd3
  } lag_action_e;

endpackage

// File: rtl/lag_rst_sync.sv
module lag_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/lag_cfg_hold.sv
module lag_cfg_hold #(
  parameter int MAX_DIMS = 6,
  parameter int ADDR_W   = 16,
  parameter int START_W  = 3,
  parameter int EXT_W    = 8,
  parameter int DIM_W    = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       idle,
  input  logic [START_W-1:0]         start_i,
  input  logic [DIM_W-1:0]           dims_i,
  input  logic [MAX_DIMS*EXT_W-1:0]  ext_i,
  input  logic [MAX_DIMS*ADDR_W-1:0] delta_i,
  output logic [ADDR_W-1:0]          start_o,
  output logic [DIM_W-1:0]           dims_o,
  output logic [MAX_DIMS*EXT_W-1:0]  ext_o,
  output logic [MAX_DIMS*ADDR_W-1:0] delta_o
);

  localparam logic [DIM_W-1:0] DIMS_MAX = DIM_W'(MAX_DIMS);

  logic [START_W-1:0]         start_q, start_d;
  logic [DIM_W-1:0]           dims_q,  dims_d;
  logic [MAX_DIMS*EXT_W-1:0]  ext_q,   ext_d;
  logic [MAX_DIMS*ADDR_W-1:0] delta_q, delta_d;
  logic [DIM_W-1:0]           dims_clamped;

  assign dims_clamped = (dims_i > DIMS_MAX) ? DIMS_MAX : dims_i;

  always_comb begin
    if (idle) begin
      start_d = start_i;
      dims_d  = dims_clamped;
      ext_d   = ext_i;
      delta_d = delta_i;
    end else begin
      start_d = start_q;
      dims_d  = dims_q;
      ext_d   = ext_q;
      delta_d = delta_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      dims_q  <= '0;
      ext_q   <= '0;
      delta_q <= '0;
    end else if (idle) begin
      start_q <= start_d;
      dims_q  <= dims_d;
      ext_q   <= ext_d;
      delta_q <= delta_d;
    end
  end

  assign start_o = ADDR_W'(start_d);
  assign dims_o  = dims_d;
  assign ext_o   = ext_d;
  assign delta_o = delta_d;

endmodule

// File: rtl/lag_level.sv
module lag_level #(
  parameter int EXT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             carry_in,
  input  logic             active,
  input  logic [EXT_W-1:0] ext_val,
  output logic             wrap_o,
  output logic             take_o
);

  localparam int CNT_W = EXT_W + 1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] limit;
  logic             hit;
  logic             cnt_en;

  assign limit  = CNT_W'(ext_val) + CNT_W'(1);
  assign hit    = (cnt_q == limit);
  assign wrap_o = carry_in & active & hit;
  assign take_o = carry_in & active & ~hit;
  assign cnt_en = clear | (carry_in & active);

  always_comb begin
    if (clear || hit) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/lag_accum.sv
module lag_accum
  import lag_pkg::*;
#(
  parameter int MAX_DIMS = 6,
  parameter int ADDR_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  lag_action_e                action,
  input  logic [ADDR_W-1:0]          start_val,
  input  logic [ADDR_W-1:0]          cur_addr,
  input  logic [MAX_DIMS-1:0]        take,
  input  logic [MAX_DIMS*ADDR_W-1:0] delta_flat,
  output logic [ADDR_W-1:0]          addr_q_o
);

  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [ADDR_W-1:0] delta_sel;
  logic              addr_en;

  always_comb begin
    delta_sel = '0;
    for (int d = 0; d < MAX_DIMS; d++) begin
      delta_sel = delta_sel | (delta_flat[d*ADDR_W +: ADDR_W] & {ADDR_W{take[d]}});
    end
  end

  always_comb begin
    unique case (action)
      ACT_ADVANCE: addr_d = cur_addr + delta_sel;
      ACT_FINISH,
      ACT_CLEAR:   addr_d = start_val;
      default:     addr_d = addr_q;
    endcase
  end

  assign addr_en = (action != ACT_HOLD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
    end
  end

  assign addr_q_o = addr_q;

endmodule

// File: rtl/loopaddr_gen.sv
module loopaddr_gen
  import lag_pkg::*;
#(
  parameter int MAX_DIMS = 6,
  parameter int ADDR_W   = 16,
  parameter int START_W  = 3,
  parameter int EXT_W    = 8,
  parameter int DIM_W    = $clog2(MAX_DIMS + 1)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       restart_i,
  input  logic                       step_i,
  input  logic [START_W-1:0]         cfg_start_i,
  input  logic [DIM_W-1:0]           cfg_dims_i,
  input  logic [MAX_DIMS*EXT_W-1:0]  cfg_extent_i,
  input  logic [MAX_DIMS*ADDR_W-1:0] cfg_delta_i,
  output logic [ADDR_W-1:0]          addr_o,
  output logic                       done_o
);

  logic                       rst_n_sync;
  logic                       idle_q, idle_d;
  logic                       done_q, done_d;
  logic [ADDR_W-1:0]          eff_start;
  logic [DIM_W-1:0]           eff_dims;
  logic [MAX_DIMS*EXT_W-1:0]  eff_ext;
  logic [MAX_DIMS*ADDR_W-1:0] eff_delta;
  logic [MAX_DIMS:0]          carry;
  logic [MAX_DIMS-1:0]        take;
  logic [MAX_DIMS-1:0]        active;
  logic                       step_go;
  logic                       all_wrap;
  logic                       lvl_clear;
  logic [ADDR_W-1:0]          addr_q;
  lag_action_e                action;

  lag_rst_sync u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  lag_cfg_hold #(
    .MAX_DIMS (MAX_DIMS),
    .ADDR_W   (ADDR_W),
    .START_W  (START_W),
    .EXT_W    (EXT_W),
    .DIM_W    (DIM_W)
  ) u_cfg_hold (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .idle    (idle_q),
    .start_i (cfg_start_i),
    .dims_i  (cfg_dims_i),
    .ext_i   (cfg_extent_i),
    .delta_i (cfg_delta_i),
    .start_o (eff_start),
    .dims_o  (eff_dims),
    .ext_o   (eff_ext),
    .delta_o (eff_delta)
  );

  assign step_go  = step_i & ~restart_i;
  assign carry[0] = step_go;

  generate
    for (genvar d = 0; d < MAX_DIMS; d++) begin : g_level
      assign active[d] = (DIM_W'(d) < eff_dims);

      lag_level #(
        .EXT_W (EXT_W)
      ) u_level (
        .clk      (clk),
        .rst_n    (rst_n_sync),
        .clear    (lvl_clear),
        .carry_in (carry[d]),
        .active   (active[d]),
        .ext_val  (eff_ext[d*EXT_W +: EXT_W]),
        .wrap_o   (carry[d+1]),
        .take_o   (take[d])
      );
    end
  endgenerate

  assign all_wrap = step_go & ~(|take);

  always_comb begin
    if (restart_i) begin
      action = ACT_CLEAR;
    end else if (all_wrap) begin
      action = ACT_FINISH;
    end else if (step_i) begin
      action = ACT_ADVANCE;
    end else begin
      action = ACT_HOLD;
    end
  end

  assign lvl_clear = (action == ACT_CLEAR) || (action == ACT_FINISH);

  always_comb begin
    idle_d = idle_q;
    done_d = 1'b0;
    unique case (action)
      ACT_CLEAR:   idle_d = 1'b1;
      ACT_FINISH: begin
        idle_d = 1'b1;
        done_d = 1'b1;
      end
      ACT_ADVANCE: idle_d = 1'b0;
      default:     idle_d = idle_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) begin
      idle_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      idle_q <= idle_d;
      done_q <= done_d;
    end
  end

  lag_accum #(
    .MAX_DIMS (MAX_DIMS),
    .ADDR_W   (ADDR_W)
  ) u_accum (
    .clk        (clk),
    .rst_n      (rst_n_sync),
    .action     (action),
    .start_val  (eff_start),
    .cur_addr   (addr_o),
    .take       (take),
    .delta_flat (eff_delta),
    .addr_q_o   (addr_q)
  );

  assign addr_o = idle_q ? eff_start : addr_q;
  assign done_o = done_q;

endmodule

// File: rtl/lag_checker.sv
module lag_checker #(
  parameter int MAX_DIMS = 6,
  parameter int ADDR_W   = 16,
  parameter int START_W  = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                restart_i,
  input logic                step_i,
  input logic [START_W-1:0]  cfg_start_i,
  input logic [ADDR_W-1:0]   addr_o,
  input logic                done_o,
  input logic                idle_q,
  input logic                step_go,
  input logic [MAX_DIMS-1:0] take
);

  p_idle_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q |-> addr_o == ADDR_W'(cfg_start_i));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle_q && !step_i && !restart_i) |=> $stable(addr_o));

  p_single_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
    step_go |-> $onehot0(take));

  p_done_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (idle_q && addr_o == ADDR_W'(cfg_start_i)));

  p_done_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($past(step_i) && !$past(restart_i)));

  p_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    restart_i |=> (idle_q && !done_o));

endmodule

bind loopaddr_gen lag_checker #(
  .MAX_DIMS (MAX_DIMS),
  .ADDR_W   (ADDR_W),
  .START_W  (START_W)
) u_lag_checker (
  .clk         (clk),
  .rst_n       (rst_n_sync),
  .restart_i   (restart_i),
  .step_i      (step_i),
  .cfg_start_i (cfg_start_i),
  .addr_o      (addr_o),
  .done_o      (done_o),
  .idle_q      (idle_q),
  .step_go     (step_go),
  .take        (take)
);

// File: tb/test_loopaddr_gen.sv
module test_loopaddr_gen;

  localparam int ND = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          restart_i = 1'b0;
  logic          step_i = 1'b0;
  logic [2:0]    cfg_start_i = '0;
  logic [2:0]    cfg_dims_i = '0;
  logic [ND*8-1:0]  cfg_extent_i = '0;
  logic [ND*16-1:0] cfg_delta_i = '0;
  logic [15:0]   addr_o;
  logic          done_o;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  bit comparing = 1'b0;
  string cur_req = "R1";
  int done_seen = 0;

  // bench configuration (true trip counts and absolute strides)
  int trip[ND];
  int stride[ND];
  int dims;
  int start;

  // reference model state
  int  m_cnt[ND];
  int  m_trip[ND];
  int  m_stride[ND];
  int  m_dims;
  int  m_start;
  bit  m_idle;
  bit  m_done;

  always #5 clk = ~clk;

  loopaddr_gen i_loopaddr_gen (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart_i    (restart_i),
    .step_i       (step_i),
    .cfg_start_i  (cfg_start_i),
    .cfg_dims_i   (cfg_dims_i),
    .cfg_extent_i (cfg_extent_i),
    .cfg_delta_i  (cfg_delta_i),
    .addr_o       (addr_o),
    .done_o       (done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // encode the bench configuration onto the ports
  task automatic apply_cfg();
    cfg_start_i = 3'(start);
    cfg_dims_i  = 3'(dims);
    for (int d = 0; d < ND; d++) begin
      int s;
      s = stride[d];
      for (int i = 0; i < d; i++) s -= stride[i] * (trip[i] - 1);
      cfg_extent_i[d*8 +: 8]  = 8'(trip[d] - 2);
      cfg_delta_i[d*16 +: 16] = 16'(s);
    end
  endtask

  function automatic int exp_addr();
    int a;
    if (m_idle) return start;
    a = m_start;
    for (int d = 0; d < ND; d++) a += m_cnt[d] * m_stride[d];
    return a & 32'hFFFF;
  endfunction

  // behavioural reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_idle = 1'b1;
      m_done = 1'b0;
      foreach (m_cnt[d]) m_cnt[d] = 0;
    end else if (restart_i) begin
      m_idle = 1'b1;
      m_done = 1'b0;
      foreach (m_cnt[d]) m_cnt[d] = 0;
    end else if (step_i) begin
      int lv;
      bit stop;
      if (m_idle) begin
        m_dims  = (dims > ND) ? ND : dims;
        m_start = start;
        foreach (m_trip[d]) begin
          m_trip[d]   = trip[d];
          m_stride[d] = stride[d];
        end
        m_idle = 1'b0;
      end
      lv = 0;
      stop = 1'b0;
      while (lv < m_dims && !stop) begin
        if (m_cnt[lv] == m_trip[lv] - 1) begin
          m_cnt[lv] = 0;
          lv++;
        end else begin
          m_cnt[lv]++;
          stop = 1'b1;
        end
      end
      if (!stop) begin
        m_done = 1'b1;
        m_idle = 1'b1;
        foreach (m_cnt[d]) m_cnt[d] = 0;
      end else begin
        m_done = 1'b0;
      end
    end else begin
      m_done = 1'b0;
    end
  end

  // compare every cycle, away from the edge
  always begin
    @(posedge clk);
    #2;
    if (comparing) begin
      check(addr_o == 16'(exp_addr()), {cur_req, " addr"}, addr_o, exp_addr());
      check(done_o == m_done, {cur_req, " done"}, done_o, m_done);
      if (done_o) done_seen++;
    end
  end

  task automatic steps(input int n);
    step_i = 1'b1;
    repeat (n) @(negedge clk);
    step_i = 1'b0;
  endtask

  task automatic set_all(input int t, input int s);
    for (int d = 0; d < ND; d++) begin
      trip[d] = t;
      stride[d] = s;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    set_all(2, 0);
    dims = 3; start = 5;
    trip[0] = 3; trip[1] = 2; trip[2] = 4;
    stride[0] = 1; stride[1] = 3; stride[2] = 6;
    apply_cfg();
    repeat (4) @(negedge clk);
    // R1: reset state
    check(addr_o == 16'd5, "R1 reset addr", addr_o, 5);
    check(done_o == 1'b0, "R1 reset done", done_o, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(addr_o == 16'd5, "R1 post-reset addr", addr_o, 5);
    comparing = 1'b1;

    // R2: idle follows start input
    cur_req = "R2";
    start = 2; apply_cfg();
    @(negedge clk);
    check(addr_o == 16'd2, "R2 idle start", addr_o, 2);
    start = 5; apply_cfg();
    @(negedge clk);

    // R4 R5 R6 R8: full pass of 24 iterations plus a second start
    cur_req = "R6";
    done_seen = 0;
    steps(26);
    check(done_seen == 1, "R8 done count", done_seen, 1);
    cur_req = "R8";
    restart_i = 1'b1; @(negedge clk); restart_i = 1'b0;

    // R3: sparse stepping pattern
    cur_req = "R3";
    for (int k = 0; k < 30; k++) begin
      step_i = (k % 3 == 0) || (k % 7 == 2);
      @(negedge clk);
    end
    step_i = 1'b0;
    repeat (3) @(negedge clk);

    // R9: restart mid-pass while step is high
    cur_req = "R9";
    step_i = 1'b1; restart_i = 1'b1; @(negedge clk);
    restart_i = 1'b0;
    steps(5);
    restart_i = 1'b1; @(negedge clk); restart_i = 1'b0;
    check(addr_o == 16'd5 && done_o == 1'b0, "R9 restart", addr_o, 5);

    // R7: inactive levels carry garbage fields
    cur_req = "R7";
    set_all(5, 777);
    dims = 2; trip[0] = 4; trip[1] = 3; stride[0] = 2; stride[1] = 11; start = 1;
    apply_cfg();
    done_seen = 0;
    steps(13);
    check(done_seen == 1, "R7 done after 12", done_seen, 1);
    dims = 7; apply_cfg();
    steps(10);
    restart_i = 1'b1; @(negedge clk); restart_i = 1'b0;

    // R10: configuration change during a pass is ignored
    cur_req = "R10";
    set_all(2, 0);
    dims = 2; trip[0] = 3; trip[1] = 3; stride[0] = 1; stride[1] = 3; start = 0;
    apply_cfg();
    steps(4);
    trip[0] = 2; trip[1] = 2; stride[0] = 10; stride[1] = 20; start = 2;
    apply_cfg();
    done_seen = 0;
    steps(5);
    check(done_seen == 1, "R10 old pass length", done_seen, 1);
    steps(4);
    check(done_seen == 2, "R10 new pass length", done_seen, 2);

    // R11: modulo wrap of the address
    cur_req = "R11";
    dims = 2; trip[0] = 3; trip[1] = 4; stride[0] = 30000; stride[1] = 9000; start = 7;
    apply_cfg();
    steps(13);

    // R4: all six levels at minimum extent
    cur_req = "R4";
    set_all(2, 1);
    for (int d = 1; d < ND; d++) stride[d] = stride[d-1] * 2 + 1;
    dims = 6; start = 3;
    apply_cfg();
    done_seen = 0;
    steps(66);
    check(done_seen == 1, "R4 six-level done", done_seen, 1);
    repeat (3) @(negedge clk);

    comparing = 1'b0;
    finished = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule